// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside the command path of a synchronous DRAM model or controller and turns one column address into the full column sequence of a burst. A mode-load strobe captures, from an address key, how long bursts are and in what order their columns are visited. A later burst-start strobe gives the first column and says whether the access is a read or a write. From then on the block steps out one column address per clock until the burst completes or is aborted.

Bursts of 1, 2, 4 and 8 beats visit an aligned block of columns in one of two orders: a wrapping up-count, or the start column with its low bits XORed with the beat number. A full-page burst walks upward through every column, wrapping at the top, until it is aborted. One key bit makes every write a single beat while reads keep the programmed length. The burst parameters are latched when a burst starts, so reloading the mode mid-burst only affects later bursts.

Top module: `burst_col_gen`

## Requirements
- R1: One cycle after `start` is sampled high, `active` is 1 and `col` equals `start_col` (beat 0).
- R2: Key bits [2:0] pick the length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. The reserved codes 100, 101 and 110 behave as 1 beat.
- R3: With key bit 3 = 0 (sequential), beat n of a finite burst of length L has its low log2(L) bits equal to (start + n) mod L, and its upper bits equal to those of the start column.
- R4: With key bit 3 = 1 (interleaved), beat n of a finite burst has its low log2(L) bits equal to the start column's low bits XOR n, and its upper bits unchanged.
- R5: A full-page burst outputs start + n modulo 256 at beat n, wrapping from 255 to 0, and ignores key bit 3. It never raises `last` and runs until aborted.
- R6: `last` is high exactly in the cycle of the final beat of a finite burst, and `active` is 0 in the next cycle. While `active` is 0, both `col` and `last` are 0.
- R7: With key bit 9 = 1, a burst started with `start_wr` = 1 is one beat long whatever the length code, and read bursts keep the programmed length. With key bit 9 = 0, writes use the programmed length.
- R8: When `abort` is sampled high during a burst and `start` is low, `active` is 0 in the next cycle.
- R9: A mode load during a burst leaves that burst's length and order unchanged. The next burst uses the new mode.
- R10: A `start` during a burst restarts at the new column with beat 0, and it takes priority over `abort` in the same cycle.
- R11: After reset, `active`, `last` and `col` are 0, and the mode is 1-beat sequential with multi-beat writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Captures `mode_key` into the mode register |
| mode_key | input | 12 | Mode key: [2:0] length code, [3] order, [9] single-beat writes |
| start | input | 1 | Begins a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| start_wr | input | 1 | 1 marks the burst as a write |
| abort | input | 1 | Ends the running burst after the current beat |
| col | output | 8 | Column address of the current beat |
| active | output | 1 | A burst is in progress |
| last | output | 1 | The current beat is the final one of a finite burst |

## Verification
The hardest situations to reach from the ports are the ones that depend on timing against a running burst. One is a mode reload in the middle of a burst, which must not change that burst. Another is a start that collides with an abort in the same cycle. The burst task can therefore pulse `mode_load` at a chosen beat and then check the rest of the burst against the old mode and the next burst against the new one. A directed sequence raises `start` and `abort` in the same cycle. The full-page wrap is reached by starting a few columns below 255 and aborting only after the column count has crossed zero.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  // Positions of the mode fields inside the load key
  localparam int LEN_LSB  = 0;
  localparam int ORD_BIT  = 3;
  localparam int WSGL_BIT = 9;

  localparam logic [2:0] LEN_FULL = 3'b111;

  typedef struct packed {
    logic [2:0] len_code;   // burst length code
    logic       ilv;        // 1 = interleaved order
    logic       wr_single;  // 1 = writes are one beat
  } mode_t;

  localparam mode_t MODE_RESET = '{len_code: 3'b000, ilv: 1'b0, wr_single: 1'b0};

  // log2 of a finite burst length; reserved codes fold to one beat
  function automatic logic [1:0] len_log2(input logic [2:0] code);
    case (code)
      3'b001:  len_log2 = 2'd1;
      3'b010:  len_log2 = 2'd2;
      3'b011:  len_log2 = 2'd3;
      default: len_log2 = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
#(
  parameter int KEY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  output mode_t            mode
);

  mode_t mode_q;
  logic  unused_key_bits;

  assign unused_key_bits = ^key;
  assign mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
    end else if (load) begin
      mode_q <= '{len_code:  key[LEN_LSB +: 3],
                  ilv:       key[ORD_BIT],
                  wr_single: key[WSGL_BIT]};
    end
  end

  // R11: reset leaves the mode at one-beat sequential
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_mode_reset_R11: assert (mode_q == MODE_RESET);
    end
  end

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             full,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  // Column of a beat: full page counts freely, finite bursts stay in the block
  function automatic logic [COL_W-1:0] beat_addr(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] n,
    input logic [COL_W-1:0] m, input logic pg, input logic x);
    logic [COL_W-1:0] sum;
    sum = b + n;
    if (pg)
      beat_addr = sum;
    else if (x)
      beat_addr = b ^ (n & m);
    else
      beat_addr = (b & ~m) | (sum & m);
  endfunction

  assign addr = beat_addr(base, beat, mask, full, ilv);

endmodule

// File: rtl/bcg_burst_seq.sv
module bcg_burst_seq
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             abort,
  output logic [COL_W-1:0] col,
  output logic             active,
  output logic             last
);

  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic             active_q, full_q, ilv_q;
  logic [1:0]       lg_q;
  logic [COL_W-1:0] base_q, beat_q;

  // named internal events
  logic             single_w, st_full_w, last_w, end_w;
  logic [1:0]       st_lg_w;
  logic [COL_W-1:0] mask_w, addr_w;

  assign single_w  = start_wr && mode.wr_single;
  assign st_full_w = (mode.len_code == LEN_FULL) && !single_w;
  assign st_lg_w   = single_w ? 2'd0 : len_log2(mode.len_code);

  assign mask_w = full_q ? '1 : ((ONE << lg_q) - ONE);
  assign last_w = active_q && !full_q && (beat_q == mask_w);
  assign end_w  = active_q && !start && (abort || last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      lg_q     <= 2'd0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      full_q   <= st_full_w;
      ilv_q    <= mode.ilv;
      lg_q     <= st_lg_w;
      base_q   <= start_col;
      beat_q   <= '0;
    end else if (active_q) begin
      if (end_w) active_q <= 1'b0;
      beat_q <= beat_q + ONE;
    end
  end

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat_q),
    .mask (mask_w),
    .full (full_q),
    .ilv  (ilv_q),
    .addr (addr_w)
  );

  assign col    = active_q ? addr_w : '0;
  assign active = active_q;
  assign last   = last_w;

  // R3/R4: a finite burst keeps the bits above its block fixed
  assert_block_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_q && !last_w && !abort && !start)
    |=> (((col ^ $past(col)) & ~$past(mask_w)) == '0));

  // R5: full page steps by one, wrapping at the top
  assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && full_q && !abort && !start)
    |=> (col == COL_W'($past(col) + ONE)) && !last);

  // R7: a write under single-beat mode is over after one beat
  assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && mode.wr_single) |=> last);

  // R9: burst parameters do not move while the burst runs
  assert_params_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start) |=> ($stable(lg_q) && $stable(full_q) && $stable(ilv_q)));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int KEY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             abort,
  output logic [COL_W-1:0] col,
  output logic             active,
  output logic             last
);

  mode_t mode;

  bcg_mode_reg #(.KEY_W(KEY_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .key   (mode_key),
    .mode  (mode)
  );

  bcg_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .start     (start),
    .start_col (start_col),
    .start_wr  (start_wr),
    .abort     (abort),
    .col       (col),
    .active    (active),
    .last      (last)
  );

  // R1 and R10: a start always opens beat 0 at the given column
  assert_start_beat0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && col == $past(start_col)));

  // R6: the final beat closes the burst
  assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active);

  // R8: abort closes the burst
  assert_abort_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && abort && !start) |=> !active);

  // R6: idle outputs are quiet
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (col == '0 && !last));

endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [11:0] mode_key = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       start_wr = 1'b0;
  logic       abort = 1'b0;
  logic [7:0] col;
  logic       active, last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench copy of the programmed mode
  int cur_code = 0;
  bit cur_ilv  = 1'b0;
  bit cur_wsgl = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_key(mode_key),
    .start(start), .start_col(start_col), .start_wr(start_wr), .abort(abort),
    .col(col), .active(active), .last(last)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // beats in a burst; 0 stands for an unbounded full page
  function automatic int burst_len(input int code, input bit wr, input bit wsgl);
    if (wr && wsgl) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int beat_col(input int s, input int n, input int len, input bit ilv);
    int off, blk;
    if (len == 0) return (s + n) % 256;
    off = s % len;
    blk = s - off;
    if (ilv) return blk + (off ^ n);
    return blk + ((off + n) % len);
  endfunction

  function automatic logic [11:0] make_key(input int code, input bit ilv, input bit wsgl);
    logic [11:0] k;
    k = 12'($urandom);          // latency and spare bits are don't-care
    k[2:0] = 3'(code);
    k[3]   = ilv;
    k[9]   = wsgl;
    return k;
  endfunction

  task automatic load_mode(input int code, input bit ilv, input bit wsgl);
    @(negedge clk);
    mode_load = 1'b1;
    mode_key  = make_key(code, ilv, wsgl);
    @(negedge clk);
    mode_load = 1'b0;
    cur_code = code; cur_ilv = ilv; cur_wsgl = wsgl;
  endtask

  task automatic check_idle(input string req);
    check(req, active, 0);
    check(req, last, 0);
    check(req, col, 0);
  endtask

  // Runs one burst. abort_at < 0: none. ml_at >= 0: reload mode at that beat.
  task automatic burst(input int s, input bit wr, input int abort_at,
                       input int ml_at, input int ml_code, input bit ml_ilv,
                       input bit ml_wsgl);
    int len;
    string req;
    len = burst_len(cur_code, wr, cur_wsgl);
    req = (wr && cur_wsgl) ? "R7" : (len == 0) ? "R5" : cur_ilv ? "R4" : "R3";
    @(negedge clk);
    start = 1'b1; start_col = 8'(s); start_wr = wr;
    @(negedge clk);
    start = 1'b0;
    check("R1", active, 1);
    for (int n = 0; n < 100000; n++) begin
      mode_load = 1'b0;
      check(req, col, beat_col(s, n, len, cur_ilv));
      check("R2,R6", last, (len != 0 && n == len - 1) ? 1 : 0);
      check("R1", active, 1);
      if (n == ml_at) begin
        mode_load = 1'b1;
        mode_key  = make_key(ml_code, ml_ilv, ml_wsgl);
      end
      if (n == abort_at) begin
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        mode_load = 1'b0;
        check_idle("R8");
        break;
      end
      if (len != 0 && n == len - 1) begin
        @(negedge clk);
        mode_load = 1'b0;
        check_idle("R6");
        break;
      end
      @(negedge clk);
    end
    if (ml_at >= 0) begin
      cur_code = ml_code; cur_ilv = ml_ilv; cur_wsgl = ml_wsgl;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_idle("R11");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11");

    // R11: power-on mode is one beat, multi-beat writes
    burst(8'h5A, 1'b0, -1, -1, 0, 0, 0);

    // R2/R3: each finite length, sequential, mid-block start
    for (int c = 0; c < 4; c++) begin
      load_mode(c, 1'b0, 1'b0);
      burst(8'h3D, 1'b0, -1, -1, 0, 0, 0);
    end
    // R4: interleaved lengths
    for (int c = 1; c < 4; c++) begin
      load_mode(c, 1'b1, 1'b0);
      burst(8'h3D, 1'b0, -1, -1, 0, 0, 0);
    end
    // R2: reserved codes act as one beat
    load_mode(5, 1'b0, 1'b0);
    burst(8'h17, 1'b0, -1, -1, 0, 0, 0);

    // R5: full page wraps 255 to 0; order bit ignored
    load_mode(7, 1'b0, 1'b0);
    burst(8'hFC, 1'b0, 9, -1, 0, 0, 0);
    load_mode(7, 1'b1, 1'b0);
    burst(8'hF0, 1'b0, 300, -1, 0, 0, 0);

    // R7: single-beat writes, reads keep length
    load_mode(3, 1'b0, 1'b1);
    burst(8'h22, 1'b1, -1, -1, 0, 0, 0);
    burst(8'h22, 1'b0, -1, -1, 0, 0, 0);
    load_mode(7, 1'b0, 1'b1);
    burst(8'h80, 1'b1, -1, -1, 0, 0, 0);
    load_mode(2, 1'b1, 1'b0);
    burst(8'h45, 1'b1, -1, -1, 0, 0, 0);

    // R8: abort inside an 8-beat burst
    load_mode(3, 1'b0, 1'b0);
    burst(8'h0B, 1'b0, 3, -1, 0, 0, 0);

    // R9: reload mid-burst, then a burst in the new mode
    load_mode(3, 1'b0, 1'b0);
    burst(8'h13, 1'b0, -1, 2, 1, 1'b1, 1'b0);
    burst(8'h13, 1'b0, -1, -1, 0, 0, 0);

    // R10: restart together with abort
    load_mode(3, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = 8'h20; start_wr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R10", col, 8'h21);
    start = 1'b1; start_col = 8'h47; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    check("R10", active, 1);
    check("R10", col, 8'h47);
    @(negedge clk);
    check("R10", col, 8'h40);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check_idle("R8");

    // random mix
    for (int i = 0; i < 80; i++) begin
      int code, ab, ml;
      code = (($urandom % 5) == 4) ? 7 : int'($urandom % 4);
      if (($urandom % 8) == 0) code = 4 + int'($urandom % 3);
      load_mode(code, 1'($urandom), 1'($urandom));
      ab = (($urandom % 3) == 0 || code == 7) ? int'($urandom % 12) : -1;
      ml = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
      burst(int'($urandom % 256), 1'($urandom), ab, ml,
            int'($urandom % 4), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule